// File: doc/BRIEF.md
# Six-Digit Multiplexed Seven-Segment Driver

This block lights six seven-segment digits one at a time through a single shared BCD-to-segment decoder. A scan position steps from 0 to 5 and wraps. On each step, every one of the four BCD bit lanes picks its bit from the digit at that position, and the decoder turns the chosen code into an active-low segment pattern for common-anode displays. The same position is decoded into a one-hot digit enable. The scan advances only on a one-cycle scan pulse, which the surrounding logic derives from the system clock. A 600 Hz pulse refreshes each digit 100 times per second.

The segment bus and the digit enable are registered together and change on the same clock edge. A digit can therefore never be driven with another digit's pattern. After reset the display is dark, and the first scan pulse lights position 0.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is held, and after reset until the first scan pulse, `seg_n_o` is 7'h7F (all segments off) and `dig_en_o` is zero.
- R2: The first scan pulse after reset sets `dig_en_o` to 6'b000001 (position 0). Each later pulse moves the single active enable bit from position k to position k+1.
- R3: A scan pulse at position 5 returns the scan to position 0.
- R4: Once the display is lit, `dig_en_o` has exactly one bit set: bit k for position k. The segment bus shows the digit held in `digits_i[4k+3:4k]`.
- R5: Segment bits 6 down to 0 drive a,b,c,d,e,f,g, active low. Codes 0 to 9 give the standard glyphs: 0=7'h01, 1=7'h4F, 2=7'h12, 3=7'h06, 4=7'h4C, 5=7'h24, 6=7'h20, 7=7'h0F, 8=7'h00, 9=7'h04.
- R6: Codes 10 to 15 blank the enabled digit, with `seg_n_o` at 7'h7F.
- R7: Without a scan pulse, the position and `dig_en_o` hold their values.
- R8: A change on the shown digit's input appears on `seg_n_o` at the first clock edge after it. Segments and enable are updated on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_tick_i | input | 1 | One-cycle pulse that advances the scan position |
| digits_i | input | 24 | Six BCD digits; digit k at bits 4k+3:4k |
| seg_n_o | output | 7 | Active-low segments, a at bit 6 through g at bit 0 |
| dig_en_o | output | 6 | One-hot active-high digit enable |

## Verification
A scan pulse sampled at a rising edge moves both outputs at that same edge. A digit input change reaches the segments at the next edge. The bench therefore drives inputs on the falling edge and samples the outputs on the following falling edge, half a cycle after the edge that must have updated them. Reset release passes through a two-stage synchronizer, so the bench waits several cycles after release before it sends its first pulse.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W  = 7;
  localparam int BCD_W  = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = 7'h7F;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int N_POS = 6,
  localparam int SEL_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [SEL_W-1:0] pos_d_o,
  output logic [SEL_W-1:0] pos_q_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_POS - 1);

  logic [SEL_W-1:0] pos_d, pos_q;

  always_comb begin
    pos_d = pos_q;
    if (tick_i) begin
      if (pos_q == LAST) pos_d = '0;
      else               pos_d = pos_q + 1'b1;
    end
  end

  // Reset parks the scan on the last position so the first pulse lands on 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= LAST;
    else         pos_q <= pos_d;
  end

  assign pos_d_o = pos_d;
  assign pos_q_o = pos_q;
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int N_DIGITS = 6,
  parameter int DIGIT_W  = 4,
  localparam int SEL_W   = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1,
  localparam int N_LANE  = 1 << SEL_W
) (
  input  logic [N_DIGITS*DIGIT_W-1:0] digits_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [DIGIT_W-1:0]          digit_o
);
  // One selector per bit lane; unused upper lanes read zero.
  for (genvar b = 0; b < DIGIT_W; b++) begin : g_lane
    logic [N_LANE-1:0] lane;
    for (genvar k = 0; k < N_LANE; k++) begin : g_in
      if (k < N_DIGITS) begin : g_used
        assign lane[k] = digits_i[k*DIGIT_W + b];
      end else begin : g_pad
        assign lane[k] = 1'b0;
      end
    end
    assign digit_o[b] = lane[sel_i];
  end
endmodule

// File: rtl/bcd7_decode.sv
module bcd7_decode
  import seg_scan_pkg::*;
(
  input  logic [BCD_W-1:0] code_i,
  output seg_t             seg_n_o
);
  seg_t lit;  // active-high a..g at bits 6..0
  always_comb begin
    unique case (code_i)
      4'd0:    lit = 7'b1111110;
      4'd1:    lit = 7'b0110000;
      4'd2:    lit = 7'b1101101;
      4'd3:    lit = 7'b1111001;
      4'd4:    lit = 7'b0110011;
      4'd5:    lit = 7'b1011011;
      4'd6:    lit = 7'b1011111;
      4'd7:    lit = 7'b1110000;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1111011;
      default: lit = 7'b0000000;
    endcase
  end
  assign seg_n_o = ~lit;
endmodule

// File: rtl/onehot_decode.sv
module onehot_decode #(
  parameter int N_OUT = 6,
  localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] hot_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign hot_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
  import seg_scan_pkg::*;
#(
  parameter int N_DIGITS = 6,
  localparam int SEL_W   = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scan_tick_i,
  input  logic [N_DIGITS*BCD_W-1:0] digits_i,
  output logic [SEG_W-1:0]          seg_n_o,
  output logic [N_DIGITS-1:0]       dig_en_o
);
  // Reset: asynchronous assertion, release aligned to the clock.
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q[1];

  logic [SEL_W-1:0] pos_d, pos_q;
  scan_counter #(.N_POS(N_DIGITS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .tick_i  (scan_tick_i),
    .pos_d_o (pos_d),
    .pos_q_o (pos_q)
  );

  // Outputs are computed from the next position so they move with the count.
  logic [BCD_W-1:0] cur_code;
  digit_select #(.N_DIGITS(N_DIGITS), .DIGIT_W(BCD_W)) u_sel (
    .digits_i (digits_i),
    .sel_i    (pos_d),
    .digit_o  (cur_code)
  );

  seg_t seg_dec;
  bcd7_decode u_dec (
    .code_i  (cur_code),
    .seg_n_o (seg_dec)
  );

  logic [N_DIGITS-1:0] en_dec;
  onehot_decode #(.N_OUT(N_DIGITS)) u_hot (
    .sel_i (pos_d),
    .hot_o (en_dec)
  );

  logic                live_d, live_q;
  seg_t                seg_d, seg_q;
  logic [N_DIGITS-1:0] en_d, en_q;

  always_comb begin
    live_d = live_q | scan_tick_i;
    seg_d  = live_d ? seg_dec : SEG_DARK;
    en_d   = live_d ? en_dec  : '0;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      live_q <= 1'b0;
      seg_q  <= SEG_DARK;
      en_q   <= '0;
    end else begin
      live_q <= live_d;
      seg_q  <= seg_d;
      en_q   <= en_d;
    end
  end

  assign seg_n_o  = seg_q;
  assign dig_en_o = en_q;

  logic unused_pos;
  assign unused_pos = ^pos_q;
endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
  parameter int N_DIGITS = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scan_tick_i,
  input logic [6:0]          seg_n_o,
  input logic [N_DIGITS-1:0] dig_en_o
);
  assert_enable_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dig_en_o));

  assert_dark_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o == '0) |-> (seg_n_o == 7'h7F));

  assert_hold_without_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_tick_i && dig_en_o != '0) |=> $stable(dig_en_o));

  assert_rotate_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_tick_i && dig_en_o != '0) |=>
      (dig_en_o == {$past(dig_en_o[N_DIGITS-2:0]), $past(dig_en_o[N_DIGITS-1])}));

  assert_stays_lit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o != '0) |=> ($countones(dig_en_o) == 1));
endmodule

bind seg_scan_driver seg_scan_checker #(.N_DIGITS(N_DIGITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_tick_i (scan_tick_i),
  .seg_n_o     (seg_n_o),
  .dig_en_o    (dig_en_o)
);

// File: tb/sim_seg_scan_driver.sv
`timescale 1ns/1ps
module sim_seg_scan_driver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [23:0] digits = '0;
  logic [6:0]  seg_n;
  logic [5:0]  dig_en;

  int n_chk = 0;
  int n_bad = 0;
  int exp_pos = 5;

  always #2 clk = ~clk;

  seg_scan_driver u0 (
    .clk_i(clk), .rst_ni(rst_n), .scan_tick_i(tick),
    .digits_i(digits), .seg_n_o(seg_n), .dig_en_o(dig_en)
  );

  function automatic logic [6:0] glyph(input logic [3:0] c);
    logic [6:0] on;
    case (c)
      4'd0: on = 7'b1111110; 4'd1: on = 7'b0110000;
      4'd2: on = 7'b1101101; 4'd3: on = 7'b1111001;
      4'd4: on = 7'b0110011; 4'd5: on = 7'b1011011;
      4'd6: on = 7'b1011111; 4'd7: on = 7'b1110000;
      4'd8: on = 7'b1111111; 4'd9: on = 7'b1111011;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got seg=%h en=%b, want seg=%h en=%b",
               req, act[12:6], act[5:0], exp[12:6], exp[5:0]);
    end
  endtask

  // Tick sampled at one edge; outputs checked at the following falling edge.
  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    exp_pos = (exp_pos == 5) ? 0 : exp_pos + 1;
  endtask

  task automatic check_shown(input string req);
    check(req, {seg_n, dig_en}, {glyph(digits[exp_pos*4 +: 4]), 6'(1 << exp_pos)});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {seg_n, dig_en}, {7'h7F, 6'b0});
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after reset", {seg_n, dig_en}, {7'h7F, 6'b0});
    exp_pos = 5;
  endtask

  task automatic t_first_and_scan();
    digits = {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    pulse();
    check("R2 first tick", {seg_n, dig_en}, {7'h01, 6'b000001});
    for (int i = 1; i < 6; i++) begin
      pulse();
      check_shown("R4 scan position");
    end
    pulse();
    check("R3 wrap to 0", {seg_n, dig_en}, {glyph(4'd0), 6'b000001});
  endtask

  task automatic t_glyphs();
    logic [6:0] tbl [10];
    tbl = '{7'h01, 7'h4F, 7'h12, 7'h06, 7'h4C, 7'h24, 7'h20, 7'h0F, 7'h00, 7'h04};
    for (int v = 0; v < 10; v++) begin
      for (int k = 0; k < 6; k++) digits[k*4 +: 4] = 4'((v + k) % 10);
      for (int s = 0; s < 6; s++) begin
        pulse();
        check("R5 glyph", {seg_n, dig_en}, {tbl[(v + exp_pos) % 10], 6'(1 << exp_pos)});
      end
    end
  endtask

  task automatic t_blank();
    digits = {4'd15, 4'd14, 4'd13, 4'd12, 4'd11, 4'd10};
    for (int s = 0; s < 6; s++) begin
      pulse();
      check("R6 blank code", {seg_n, dig_en}, {7'h7F, 6'(1 << exp_pos)});
    end
  endtask

  task automatic t_hold();
    digits = {4'd9, 4'd8, 4'd7, 4'd6, 4'd5, 4'd4};
    pulse();
    repeat (20) @(negedge clk);
    check_shown("R7 hold without tick");
  endtask

  task automatic t_live_change();
    @(negedge clk);
    digits[exp_pos*4 +: 4] = 4'd2;
    @(negedge clk);
    check_shown("R8 input change next edge");
    digits[exp_pos*4 +: 4] = 4'd13;
    @(negedge clk);
    check("R8 change to blank", {seg_n, dig_en}, {7'h7F, 6'(1 << exp_pos)});
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_first_and_scan();
    t_glyphs();
    t_blank();
    t_hold();
    t_live_change();
    t_reset();
    t_first_and_scan();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule